// File: doc/BRIEF.md
# Character I/O Handshake Flag Controller

This block is the device-side control for one byte-wide input channel and one byte-wide output channel on a minicomputer I/O bus. Each direction has one data register and one ready flag. The CPU reaches the block in three ways:

- A data write loads the output register and starts a transfer to the sink.
- A function-out command word clears flags and can request a fetch.
- A sense query returns a skip bit built from the flags.

Each ready flag drives an interrupt request through its own enable input.

Input bytes arrive on a single valid strobe, with a separate break strobe for a line break. Output bytes leave on a valid/ready handshake. With the default reader variant (`READER_MODE=1`), the input side accepts a byte only after a start command has armed a single fetch. With `READER_MODE=0`, every strobed byte is taken. The CPU sees the input register at all times on a read port that has no side effects.

Top module: `chario_flag_ctrl`

## Requirements
- R1: After reset, both data registers are zero, input-ready is 0, output-ready is 1, no output transfer is in progress (`snk_valid_o`=0) and no fetch is pending (`fetch_req_o`=0).
- R2: A data write (`wr_en_i`=1) stores only `wr_data_i[7:0]` in the output register and clears output-ready. From the next cycle, `snk_valid_o`=1 with that byte on `snk_data_o`. A write wins over a transfer that completes in the same cycle.
- R3: While `snk_valid_o`=1 and `snk_ready_i`=0, the output byte holds stable. A cycle with both high completes the transfer: the next cycle has `snk_valid_o`=0 and output-ready set.
- R4: An accepted input byte (`src_valid_i`=1) is loaded into the input register shown on `rd_data_o`, sets input-ready and ends any pending fetch, all visible the next cycle.
- R5: An accepted break (`src_break_i`=1, which takes priority over `src_data_i`) loads zero into the input register and sets input-ready.
- R6: In `fo_cmd_i`, bit 0 clears input-ready and bit 1 clears output-ready; both may be set in one word. A set event (byte accepted, transfer complete) in the same cycle as a clear wins.
- R7: `sense_o` = (`sense_sel_i[0]` AND input-ready) OR (`sense_sel_i[1]` AND output-ready), combinationally.
- R8: With `READER_MODE=1`, `fo_cmd_i` bit 2 arms one fetch, shown on `fetch_req_o` from the next cycle. Bytes and breaks are ignored while no fetch is armed. A start command while a fetch is armed has no effect, so exactly one byte is taken per fetch.
- R9: `in_irq_o` = input-ready AND `in_ien_i`, and `out_irq_o` = output-ready AND `out_ien_i`.
- R10: With `READER_MODE=0`, every strobed byte or break is accepted, the start bit is ignored, and `fetch_req_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | CPU data write strobe |
| wr_data_i | input | 16 | CPU write data; low byte used |
| fo_en_i | input | 1 | Function-out command strobe |
| fo_cmd_i | input | 3 | Command bits: 0 clear input-ready, 1 clear output-ready, 2 start fetch |
| sense_sel_i | input | 2 | Sense select: 0 input side, 1 output side |
| sense_o | output | 1 | Skip response |
| rd_data_o | output | 8 | Input register, side-effect-free read |
| in_ien_i | input | 1 | Input interrupt enable |
| out_ien_i | input | 1 | Output interrupt enable |
| in_irq_o | output | 1 | Input interrupt request |
| out_irq_o | output | 1 | Output interrupt request |
| src_valid_i | input | 1 | Input byte strobe |
| src_break_i | input | 1 | Input break strobe |
| src_data_i | input | 8 | Input byte |
| fetch_req_o | output | 1 | A fetch is armed |
| snk_valid_o | output | 1 | Output byte valid |
| snk_ready_i | input | 1 | Sink accepts output byte |
| snk_data_o | output | 8 | Output byte |

## Verification
The assertions check on every cycle the local cause-and-effect rules:

- a write arms the output with the low byte;
- a pending output holds stable until accepted;
- a completed handshake drops valid and sets the flag;
- an accepted byte or break lands in the register and ends the fetch;
- the input register never moves while the reader has no fetch armed;
- a clear with no competing set event empties its flag.

Only the bench scenarios can show the sequences that need history. These are one byte per start across repeated starts, set-over-clear races in the same cycle, the divergence between reader and free-running variants under identical stimulus, and the combinational sense and interrupt gating against a reference model over long random runs.

// File: rtl/chario_pkg.sv
package chario_pkg;
  localparam int unsigned FO_W       = 3;
  localparam int unsigned FO_CLR_IN  = 0;
  localparam int unsigned FO_CLR_OUT = 1;
  localparam int unsigned FO_START   = 2;
  localparam int unsigned NUM_CH     = 2;
  localparam int unsigned CH_IN      = 0;
  localparam int unsigned CH_OUT     = 1;
endpackage

// File: rtl/chario_in_chan.sv
module chario_in_chan #(
  parameter int unsigned DATA_W      = 8,
  parameter bit          READER_MODE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clr_i,
  input  logic              src_valid_i,
  input  logic              src_break_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o,
  output logic              fetch_o
);
  logic [DATA_W-1:0] data_q;
  logic              rdy_q;
  logic              take_ok;
  logic              take;

  assign take = (src_valid_i | src_break_i) & take_ok;

  generate
    if (READER_MODE) begin : g_reader
      logic pend_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                pend_q <= 1'b0;
        else if (take)              pend_q <= 1'b0;
        else if (start_i && !pend_q) pend_q <= 1'b1;
      end
      assign take_ok = pend_q;
      assign fetch_o = pend_q;

      assert_no_take_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pend_q |=> $stable(data_q));
      assert_fetch_ends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q && src_valid_i) |=> !pend_q);
    end else begin : g_free
      logic unused_start;
      assign unused_start = start_i;
      assign take_ok = 1'b1;
      assign fetch_o = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
    end else if (take) begin
      data_q <= src_break_i ? '0 : src_data_i;
      rdy_q  <= 1'b1;
    end else if (clr_i) begin
      rdy_q  <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign rdy_o  = rdy_q;

  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !src_break_i) |=> (rdy_q && data_q == $past(src_data_i)));
  assert_break_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && src_break_i) |=> (rdy_q && data_q == '0));
  assert_clr_in_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !src_valid_i && !src_break_i) |=> !rdy_q);
endmodule

// File: rtl/chario_out_chan.sv
module chario_out_chan #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BUS_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  input  logic              clr_i,
  input  logic              snk_ready_i,
  output logic              snk_valid_o,
  output logic [DATA_W-1:0] snk_data_o,
  output logic              rdy_o
);
  logic [DATA_W-1:0] data_q;
  logic              busy_q;
  logic              rdy_q;

  generate
    if (BUS_W > DATA_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wr_data_i[BUS_W-1:DATA_W];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      busy_q <= 1'b0;
      rdy_q  <= 1'b1;
    end else if (wr_i) begin
      data_q <= wr_data_i[DATA_W-1:0];
      busy_q <= 1'b1;
      rdy_q  <= 1'b0;
    end else if (busy_q && snk_ready_i) begin
      busy_q <= 1'b0;
      rdy_q  <= 1'b1;
    end else if (clr_i) begin
      rdy_q  <= 1'b0;
    end
  end

  assign snk_valid_o = busy_q;
  assign snk_data_o  = data_q;
  assign rdy_o       = rdy_q;

  assert_wr_arms_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (snk_valid_o && !rdy_q && snk_data_o == $past(wr_data_i[DATA_W-1:0])));
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snk_valid_o && !snk_ready_i && !wr_i) |=> (snk_valid_o && $stable(snk_data_o)));
  assert_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snk_valid_o && snk_ready_i && !wr_i) |=> (!snk_valid_o && rdy_q));
  assert_clr_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wr_i && !(snk_valid_o && snk_ready_i)) |=> !rdy_q);
endmodule

// File: rtl/chario_irq_sense.sv
module chario_irq_sense #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] flag_i,
  input  logic [NUM_CH-1:0] ien_i,
  input  logic [NUM_CH-1:0] sel_i,
  output logic [NUM_CH-1:0] irq_o,
  output logic              sense_o
);
  logic [NUM_CH-1:0] hit;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign irq_o[g] = flag_i[g] & ien_i[g];
    assign hit[g]   = flag_i[g] & sel_i[g];
  end

  assign sense_o = |hit;
endmodule

// File: rtl/chario_flag_ctrl.sv
module chario_flag_ctrl
  import chario_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned BUS_W       = 16,
  parameter bit          READER_MODE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  input  logic              fo_en_i,
  input  logic [FO_W-1:0]   fo_cmd_i,
  input  logic [NUM_CH-1:0] sense_sel_i,
  output logic              sense_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              in_ien_i,
  input  logic              out_ien_i,
  output logic              in_irq_o,
  output logic              out_irq_o,
  input  logic              src_valid_i,
  input  logic              src_break_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              fetch_req_o,
  output logic              snk_valid_o,
  input  logic              snk_ready_i,
  output logic [DATA_W-1:0] snk_data_o
);
  logic              clr_in, clr_out, start;
  logic [NUM_CH-1:0] flags, ien, irq;

  assign clr_in  = fo_en_i & fo_cmd_i[FO_CLR_IN];
  assign clr_out = fo_en_i & fo_cmd_i[FO_CLR_OUT];
  assign start   = fo_en_i & fo_cmd_i[FO_START];

  chario_in_chan #(.DATA_W(DATA_W), .READER_MODE(READER_MODE)) u_in (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .clr_i       (clr_in),
    .src_valid_i (src_valid_i),
    .src_break_i (src_break_i),
    .src_data_i  (src_data_i),
    .data_o      (rd_data_o),
    .rdy_o       (flags[CH_IN]),
    .fetch_o     (fetch_req_o)
  );

  chario_out_chan #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_en_i),
    .wr_data_i   (wr_data_i),
    .clr_i       (clr_out),
    .snk_ready_i (snk_ready_i),
    .snk_valid_o (snk_valid_o),
    .snk_data_o  (snk_data_o),
    .rdy_o       (flags[CH_OUT])
  );

  assign ien[CH_IN]  = in_ien_i;
  assign ien[CH_OUT] = out_ien_i;

  chario_irq_sense #(.NUM_CH(NUM_CH)) u_irq (
    .flag_i  (flags),
    .ien_i   (ien),
    .sel_i   (sense_sel_i),
    .irq_o   (irq),
    .sense_o (sense_o)
  );

  assign in_irq_o  = irq[CH_IN];
  assign out_irq_o = irq[CH_OUT];

  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_ien_i && !out_ien_i) |-> (!in_irq_o && !out_irq_o));
  assert_skip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_sel_i == '0) |-> !sense_o);
endmodule

// File: tb/tb_chario_flag_ctrl.sv
module tb_chario_flag_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        fo_en = 1'b0;
  logic [2:0]  fo_cmd = '0;
  logic [1:0]  sel = '0;
  logic        in_ien = 1'b0, out_ien = 1'b0;
  logic        src_valid = 1'b0, src_break = 1'b0;
  logic [7:0]  src_data = '0;
  logic        snk_ready = 1'b0;

  logic       r_sense, r_iirq, r_oirq, r_fetch, r_sv;
  logic [7:0] r_rd, r_sd;
  logic       f_sense, f_iirq, f_oirq, f_fetch, f_sv;
  logic [7:0] f_rd, f_sd;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  chario_flag_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .fo_en_i(fo_en), .fo_cmd_i(fo_cmd), .sense_sel_i(sel), .sense_o(r_sense),
    .rd_data_o(r_rd), .in_ien_i(in_ien), .out_ien_i(out_ien),
    .in_irq_o(r_iirq), .out_irq_o(r_oirq), .src_valid_i(src_valid),
    .src_break_i(src_break), .src_data_i(src_data), .fetch_req_o(r_fetch),
    .snk_valid_o(r_sv), .snk_ready_i(snk_ready), .snk_data_o(r_sd));

  chario_flag_ctrl #(.READER_MODE(1'b0)) dut_free (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .fo_en_i(fo_en), .fo_cmd_i(fo_cmd), .sense_sel_i(sel), .sense_o(f_sense),
    .rd_data_o(f_rd), .in_ien_i(in_ien), .out_ien_i(out_ien),
    .in_irq_o(f_iirq), .out_irq_o(f_oirq), .src_valid_i(src_valid),
    .src_break_i(src_break), .src_data_i(src_data), .fetch_req_o(f_fetch),
    .snk_valid_o(f_sv), .snk_ready_i(snk_ready), .snk_data_o(f_sd));

  typedef struct packed {
    logic [7:0] in_reg;
    logic       in_rdy;
    logic       pend;
    logic [7:0] out_reg;
    logic       out_rdy;
    logic       busy;
  } m_t;

  m_t m_r, m_f;

  function automatic m_t m_reset();
    m_t s;
    s = '0;
    s.out_rdy = 1'b1;
    return s;
  endfunction

  function automatic m_t m_step(m_t s, bit reader);
    m_t n = s;
    bit take = (src_valid | src_break) && (!reader || s.pend);
    if (fo_en && fo_cmd[2] && reader && !s.pend) n.pend = 1'b1;
    if (fo_en && fo_cmd[0]) n.in_rdy = 1'b0;
    if (take) begin
      n.in_reg = src_break ? 8'h00 : src_data;
      n.in_rdy = 1'b1;
      n.pend   = 1'b0;
    end
    if (fo_en && fo_cmd[1]) n.out_rdy = 1'b0;
    if (s.busy && snk_ready) begin
      n.busy = 1'b0;
      n.out_rdy = 1'b1;
    end
    if (wr_en) begin
      n.out_reg = wr_data[7:0];
      n.busy = 1'b1;
      n.out_rdy = 1'b0;
    end
    return n;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp(string who, m_t m, logic [7:0] rd, logic sn, logic ii,
                     logic oi, logic fr, logic sv, logic [7:0] sd);
    chk({who, " R4 rd_data"}, 16'(rd), 16'(m.in_reg));
    chk({who, " R7 sense"}, 16'(sn), 16'((sel[0] & m.in_rdy) | (sel[1] & m.out_rdy)));
    chk({who, " R9 in_irq"}, 16'(ii), 16'(m.in_rdy & in_ien));
    chk({who, " R9 out_irq"}, 16'(oi), 16'(m.out_rdy & out_ien));
    chk({who, " R8 fetch"}, 16'(fr), 16'(m.pend));
    chk({who, " R3 snk_valid"}, 16'(sv), 16'(m.busy));
    if (m.busy) chk({who, " R2 snk_data"}, 16'(sd), 16'(m.out_reg));
  endtask

  task automatic cyc();
    @(posedge clk);
    m_r = m_step(m_r, 1'b1);
    m_f = m_step(m_f, 1'b0);
    @(negedge clk);
    cmp("rdr", m_r, r_rd, r_sense, r_iirq, r_oirq, r_fetch, r_sv, r_sd);
    cmp("free", m_f, f_rd, f_sense, f_iirq, f_oirq, f_fetch, f_sv, f_sd);
  endtask

  task automatic idle();
    wr_en = 0; fo_en = 0; fo_cmd = '0; src_valid = 0; src_break = 0; snk_ready = 0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    m_r = m_reset();
    m_f = m_reset();
    in_ien = 1; out_ien = 1; sel = 2'b11;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", 16'(r_rd), 16'h0);
    chk("R1 snk_valid", 16'(r_sv), 16'h0);
    chk("R1 fetch", 16'(r_fetch), 16'h0);
    chk("R1 in_irq", 16'(r_iirq), 16'h0);
    chk("R1 out_irq", 16'(r_oirq), 16'h1);
    chk("R1 snk_data", 16'(r_sd), 16'h0);
    rst_n = 1;
    @(negedge clk);

    // R2 write low byte only
    idle(); wr_en = 1; wr_data = 16'h3C5A; cyc();
    chk("R2 valid", 16'(r_sv), 16'h1);
    chk("R2 data", 16'(r_sd), 16'h5A);
    chk("R2 out_irq", 16'(r_oirq), 16'h0);
    // R3 hold, then complete
    idle(); cyc();
    chk("R3 hold valid", 16'(r_sv), 16'h1);
    chk("R3 hold data", 16'(r_sd), 16'h5A);
    snk_ready = 1; cyc();
    chk("R3 done valid", 16'(r_sv), 16'h0);
    chk("R3 done flag", 16'(r_oirq), 16'h1);
    // R8 no byte without start; R10 free mode takes it
    idle(); src_valid = 1; src_data = 8'h77; cyc();
    chk("R8 ignored rd", 16'(r_rd), 16'h0);
    chk("R8 ignored flag", 16'(r_iirq), 16'h0);
    chk("R10 free rd", 16'(f_rd), 16'h77);
    chk("R10 free flag", 16'(f_iirq), 16'h1);
    idle(); fo_en = 1; fo_cmd = 3'b100; cyc();
    chk("R8 fetch armed", 16'(r_fetch), 16'h1);
    chk("R10 free fetch", 16'(f_fetch), 16'h0);
    cyc();
    chk("R8 second start", 16'(r_fetch), 16'h1);
    idle(); src_valid = 1; src_data = 8'h91; cyc();
    chk("R4 rd", 16'(r_rd), 16'h91);
    chk("R4 flag", 16'(r_iirq), 16'h1);
    chk("R4 fetch end", 16'(r_fetch), 16'h0);
    src_data = 8'h22; cyc();
    chk("R8 one per start", 16'(r_rd), 16'h91);
    // R6 single clear
    idle(); fo_en = 1; fo_cmd = 3'b001; cyc();
    chk("R6 clr in", 16'(r_iirq), 16'h0);
    chk("R6 out kept", 16'(r_oirq), 16'h1);
    // R7 select terms
    idle(); sel = 2'b01; #1;
    chk("R7 sel in", 16'(r_sense), 16'h0);
    sel = 2'b10; #1;
    chk("R7 sel out", 16'(r_sense), 16'h1);
    sel = 2'b11;
    @(negedge clk);
    // R5 break
    fo_en = 1; fo_cmd = 3'b100; cyc();
    idle(); src_break = 1; src_data = 8'hFF; cyc();
    chk("R5 break rd", 16'(r_rd), 16'h0);
    chk("R5 break flag", 16'(r_iirq), 16'h1);
    // R6 both clears
    idle(); fo_en = 1; fo_cmd = 3'b011; cyc();
    chk("R6 both in", 16'(r_iirq), 16'h0);
    chk("R6 both out", 16'(r_oirq), 16'h0);
    // R6 set wins over clear
    idle(); wr_en = 1; wr_data = 16'h0011; cyc();
    idle(); snk_ready = 1; fo_en = 1; fo_cmd = 3'b010; cyc();
    chk("R6 set wins", 16'(r_oirq), 16'h1);
    // R9 enables off
    idle(); in_ien = 0; out_ien = 0; cyc();
    chk("R9 irq gated", 16'(r_oirq), 16'h0);
    chk("R9 sense still", 16'(r_sense), 16'h1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      wr_en     = ($urandom % 8) == 0;
      wr_data   = 16'($urandom);
      fo_en     = ($urandom % 5) == 0;
      fo_cmd    = 3'($urandom);
      sel       = 2'($urandom);
      in_ien    = 1'($urandom);
      out_ien   = 1'($urandom);
      src_valid = ($urandom % 3) == 0;
      src_break = ($urandom % 40) == 0;
      src_data  = 8'($urandom);
      snk_ready = 1'($urandom);
      cyc();
    end
    idle();
    finish_run();
  end
endmodule